// File: doc/BRIEF.md
# ADC Sample Sequencer Controller

This block walks a programmed list of converter sample slots and collects the results. Each slot carries an input-select code and a four-bit control field. For the active slot the block presents a mux select and a differential-mode flag to an external converter. It pulses a start strobe and then waits for a done handshake that carries a 12-bit result. Each result is written into a local circular FIFO, whose depth equals the slot count. Software takes results out by reading one port.

Software writes the slot configuration, sets the enable input and pulses the initiate input. The sequence runs from slot 0 until it reaches a slot whose end flag is set, or until the last implemented slot. Slots can request an interrupt pulse once their sample is stored. A slot can also replace its input select with a fixed internal temperature-sensor code. Status outputs show the FIFO head and tail pointers, the full and empty flags, and two sticky error flags. One flags results that were dropped because the FIFO was full. The other flags reads made while the FIFO was empty.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A sequence starts only when initiate is high while enable is high and the block is idle. Initiate while enable is low does nothing. Driving enable low during a sequence returns the block to idle on the next clock, and a later done pulse is ignored.
- R2: Slots are visited in ascending order starting at slot 0. conv_start is high for exactly one cycle per slot, and the block waits for conv_done before it moves on. The same select code may appear in several slots, and conv_sel carries that slot's code from cfg_sel bits [i*SEL_W +: SEL_W].
- R3: Slot i's control field is cfg_ctl[4*i +: 4]. Bit 0 is differential mode, bit 1 is end of sequence, bit 2 is interrupt enable and bit 3 is sensor select. conv_diff equals bit 0 of the active slot.
- R4: A slot with its end bit set is the last slot converted. If no slot has the bit set, the sequence ends after slot NUM_SLOTS-1. busy is high from the cycle after initiate until the final done is accepted.
- R5: irq pulses high for one cycle in the cycle after the done of each slot whose interrupt-enable bit is set, and at no other time.
- R6: When a slot's sensor bit is set, conv_sel shows SENSOR_SEL (all ones by default), whatever that slot's select code is.
- R7: Each accepted result enters the FIFO in order. rd_data shows the oldest entry as {20'b0, result}. A read with rd_en high removes that entry. rd_data reads zero while the FIFO is empty.
- R8: A result that arrives while the FIFO is full is discarded and does not disturb the stored entries. fifo_ovf then goes high and stays high.
- R9: A read while the FIFO is empty leaves the pointers unchanged. fifo_unf then goes high and stays high.
- R10: A one-cycle pulse on clr_ovf or clr_unf clears the matching flag. If a new error occurs in the same cycle as the clear, the flag stays set.
- R11: Initiate pulses that arrive while a sequence is running are ignored, so only one pass through the slots takes place.
- R12: fifo_tail counts writes modulo the depth and fifo_head counts reads modulo the depth. fifo_full and fifo_empty are never high together. After reset the FIFO is empty, both pointers are zero, and busy, irq and both error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Sequencer enable |
| initiate | input | 1 | Start request |
| cfg_sel | input | NUM_SLOTS*SEL_W | Input-select code per slot |
| cfg_ctl | input | NUM_SLOTS*4 | Control field per slot |
| conv_start | output | 1 | One-cycle conversion start |
| conv_sel | output | SEL_W | Mux select for the active slot |
| conv_diff | output | 1 | Differential mode for the active slot |
| conv_done | input | 1 | Conversion complete, result valid |
| conv_result | input | 12 | Conversion result |
| rd_en | input | 1 | Pop the oldest FIFO entry |
| rd_data | output | 32 | Oldest FIFO entry, zero-extended |
| clr_ovf | input | 1 | Clear the overflow flag |
| clr_unf | input | 1 | Clear the underflow flag |
| irq | output | 1 | Per-sample interrupt pulse |
| busy | output | 1 | Sequence in progress |
| fifo_head | output | PW | Read pointer |
| fifo_tail | output | PW | Write pointer |
| fifo_full | output | 1 | FIFO full |
| fifo_empty | output | 1 | FIFO empty |
| fifo_ovf | output | 1 | Sticky overflow flag |
| fifo_unf | output | 1 | Sticky underflow flag |

## Verification
The bench sets end flags at early, middle and missing positions. A design that miscounts the slots would convert one slot too many or too few, or would stop at the wrong boundary. It runs two sequences without reading, so results arrive while the FIFO is full. A design that overwrites the oldest entry, or lets the write pointer move, then returns the wrong values when the FIFO is drained. Reads on an empty FIFO and clears that coincide with a new error expose flags that are not sticky, or a clear that wins over a new error. Initiate pulses during a sequence, initiate while disabled, and enable dropped part way through catch a block that restarts, runs when it should not, or keeps accepting results after it is stopped.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    localparam int RES_W  = 12;
    localparam int WORD_W = 32;
    localparam int CTL_W  = 4;

    // control field of one slot, bit 0 first from the right
    typedef struct packed {
        logic sensor;
        logic irq_en;
        logic last;
        logic diff;
    } slot_ctl_t;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_START = 2'd1,
        SEQ_WAIT  = 2'd2
    } seq_state_e;

    function automatic int ptr_w(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input logic [RES_W-1:0] r);
        return {{(WORD_W-RES_W){1'b0}}, r};
    endfunction

endpackage

// File: rtl/adcseq_fsm.sv
module adcseq_fsm
    import adcseq_pkg::*;
#(
    parameter int               NUM_SLOTS  = 8,
    parameter int               SEL_W      = 4,
    parameter logic [SEL_W-1:0] SENSOR_SEL = '1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       enable,
    input  logic                       initiate,
    input  logic [NUM_SLOTS*SEL_W-1:0] cfg_sel,
    input  logic [NUM_SLOTS*CTL_W-1:0] cfg_ctl,
    input  logic                       conv_done,
    output logic                       conv_start,
    output logic [SEL_W-1:0]           conv_sel,
    output logic                       conv_diff,
    output logic                       push,
    output logic                       irq,
    output logic                       busy
);

    localparam int             IW       = ptr_w(NUM_SLOTS);
    localparam logic [IW-1:0]  LAST_IDX = IW'(NUM_SLOTS - 1);

    seq_state_e       state_q, state_d;
    logic [IW-1:0]    slot_q, slot_d;
    slot_ctl_t        cur_ctl;
    logic [SEL_W-1:0] cur_sel;
    logic             accept;
    logic             irq_q;

    always_comb begin
        cur_ctl = slot_ctl_t'(cfg_ctl[slot_q*CTL_W +: CTL_W]);
        cur_sel = cfg_sel[slot_q*SEL_W +: SEL_W];
    end

    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        accept  = 1'b0;
        case (state_q)
            SEQ_IDLE: begin
                if (enable && initiate) begin
                    state_d = SEQ_START;
                    slot_d  = '0;
                end
            end
            SEQ_START: begin
                state_d = enable ? SEQ_WAIT : SEQ_IDLE;
            end
            SEQ_WAIT: begin
                if (conv_done) begin
                    accept = 1'b1;
                    if (cur_ctl.last || (slot_q == LAST_IDX) || !enable) begin
                        state_d = SEQ_IDLE;
                    end else begin
                        state_d = SEQ_START;
                        slot_d  = slot_q + IW'(1);
                    end
                end else if (!enable) begin
                    state_d = SEQ_IDLE;
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            slot_q  <= '0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            irq_q   <= accept && cur_ctl.irq_en;
        end
    end

    assign conv_start = (state_q == SEQ_START);
    assign conv_sel   = cur_ctl.sensor ? SENSOR_SEL : cur_sel;
    assign conv_diff  = cur_ctl.diff;
    assign push       = accept;
    assign irq        = irq_q;
    assign busy       = (state_q != SEQ_IDLE);

    // R2: the start strobe lasts one cycle per slot
    a_r2_start_pulse: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    // R1: the block stays idle unless enable and initiate arrive together
    a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !(enable && initiate)) |=> !busy);

    // R5: an interrupt pulse always follows a done handshake
    a_r5_irq_after_done: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(conv_done));

    // R11: while waiting on the converter no new start is issued
    a_r11_wait_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && !conv_start && !conv_done && enable) |=> (busy && !conv_start));

endmodule

// File: rtl/adcseq_fifo.sv
module adcseq_fifo
    import adcseq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW   = ptr_w(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [RES_W-1:0]  wdata,
    input  logic              pop_req,
    input  logic              clr_ovf,
    input  logic              clr_unf,
    output logic [WORD_W-1:0] rdata,
    output logic [PW-1:0]     head,
    output logic [PW-1:0]     tail,
    output logic              full,
    output logic              empty,
    output logic              ovf,
    output logic              unf
);

    localparam int CW = $clog2(DEPTH + 1);

    logic [RES_W-1:0] mem [DEPTH];
    logic [PW-1:0]    head_q, tail_q, head_nx, tail_nx;
    logic [CW-1:0]    cnt_q;
    logic             ovf_q, unf_q;
    logic             do_wr, do_rd;

    assign full  = (cnt_q == CW'(DEPTH));
    assign empty = (cnt_q == '0);
    assign do_wr = push && !full;
    assign do_rd = pop_req && !empty;

    generate
        if (DEPTH == 1) begin : g_single
            assign head_nx = '0;
            assign tail_nx = '0;
        end else begin : g_ring
            assign head_nx = (head_q == PW'(DEPTH - 1)) ? '0 : head_q + PW'(1);
            assign tail_nx = (tail_q == PW'(DEPTH - 1)) ? '0 : tail_q + PW'(1);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[tail_q] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
            ovf_q  <= 1'b0;
            unf_q  <= 1'b0;
        end else begin
            if (do_wr) tail_q <= tail_nx;
            if (do_rd) head_q <= head_nx;
            case ({do_wr, do_rd})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
            ovf_q <= (ovf_q && !clr_ovf) || (push && full);
            unf_q <= (unf_q && !clr_unf) || (pop_req && empty);
        end
    end

    assign rdata = empty ? '0 : pack_word(mem[head_q]);
    assign head  = head_q;
    assign tail  = tail_q;
    assign ovf   = ovf_q;
    assign unf   = unf_q;

    // R8: a write into a full FIFO leaves the write pointer and fill state alone
    a_r8_full_drop: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop_req) |=> ($stable(tail) && full));

    // R8: the overflow flag holds until cleared
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf && !clr_ovf) |=> ovf);

    // R9: a read from an empty FIFO raises underflow and keeps the read pointer
    a_r9_unf_set: assert property (@(posedge clk) disable iff (rst)
        (pop_req && empty) |=> (unf && $stable(head)));

    // R12: full and empty are mutually exclusive
    a_r12_flags_excl: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adcseq_pkg::*;
#(
    parameter int               NUM_SLOTS  = 8,
    parameter int               SEL_W      = 4,
    parameter logic [SEL_W-1:0] SENSOR_SEL = '1,
    localparam int              PW         = ptr_w(NUM_SLOTS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       enable,
    input  logic                       initiate,
    input  logic [NUM_SLOTS*SEL_W-1:0] cfg_sel,
    input  logic [NUM_SLOTS*CTL_W-1:0] cfg_ctl,
    output logic                       conv_start,
    output logic [SEL_W-1:0]           conv_sel,
    output logic                       conv_diff,
    input  logic                       conv_done,
    input  logic [RES_W-1:0]           conv_result,
    input  logic                       rd_en,
    output logic [WORD_W-1:0]          rd_data,
    input  logic                       clr_ovf,
    input  logic                       clr_unf,
    output logic                       irq,
    output logic                       busy,
    output logic [PW-1:0]              fifo_head,
    output logic [PW-1:0]              fifo_tail,
    output logic                       fifo_full,
    output logic                       fifo_empty,
    output logic                       fifo_ovf,
    output logic                       fifo_unf
);

    logic push;

    adcseq_fsm #(
        .NUM_SLOTS  (NUM_SLOTS),
        .SEL_W      (SEL_W),
        .SENSOR_SEL (SENSOR_SEL)
    ) i_fsm (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .initiate   (initiate),
        .cfg_sel    (cfg_sel),
        .cfg_ctl    (cfg_ctl),
        .conv_done  (conv_done),
        .conv_start (conv_start),
        .conv_sel   (conv_sel),
        .conv_diff  (conv_diff),
        .push       (push),
        .irq        (irq),
        .busy       (busy)
    );

    adcseq_fifo #(
        .DEPTH (NUM_SLOTS)
    ) i_fifo (
        .clk     (clk),
        .rst     (rst),
        .push    (push),
        .wdata   (conv_result),
        .pop_req (rd_en),
        .clr_ovf (clr_ovf),
        .clr_unf (clr_unf),
        .rdata   (rd_data),
        .head    (fifo_head),
        .tail    (fifo_tail),
        .full    (fifo_full),
        .empty   (fifo_empty),
        .ovf     (fifo_ovf),
        .unf     (fifo_unf)
    );

endmodule

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int SW = 4;
    localparam int PW = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            enable = 1'b0;
    logic            initiate = 1'b0;
    logic [N*SW-1:0] cfg_sel = '0;
    logic [N*4-1:0]  cfg_ctl = '0;
    logic            conv_start;
    logic [SW-1:0]   conv_sel;
    logic            conv_diff;
    logic            conv_done = 1'b0;
    logic [11:0]     conv_result = '0;
    logic            rd_en = 1'b0;
    logic [31:0]     rd_data;
    logic            clr_ovf = 1'b0;
    logic            clr_unf = 1'b0;
    logic            irq;
    logic            busy;
    logic [PW-1:0]   fifo_head, fifo_tail;
    logic            fifo_full, fifo_empty, fifo_ovf, fifo_unf;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_seq_ctrl #(.NUM_SLOTS(N), .SEL_W(SW)) i_adc_seq_ctrl (
        .clk(clk), .rst(rst), .enable(enable), .initiate(initiate),
        .cfg_sel(cfg_sel), .cfg_ctl(cfg_ctl),
        .conv_start(conv_start), .conv_sel(conv_sel), .conv_diff(conv_diff),
        .conv_done(conv_done), .conv_result(conv_result),
        .rd_en(rd_en), .rd_data(rd_data), .clr_ovf(clr_ovf), .clr_unf(clr_unf),
        .irq(irq), .busy(busy), .fifo_head(fifo_head), .fifo_tail(fifo_tail),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .fifo_ovf(fifo_ovf), .fifo_unf(fifo_unf)
    );

    int checks = 0;
    int errors = 0;

    logic [SW-1:0] cs [N];
    logic [3:0]    cc [N];

    logic [SW-1:0] log_sel  [64];
    logic          log_diff [64];
    int            log_n = 0;
    int            irq_cnt = 0;
    int            conv_total = 0;
    bit            pending = 0;
    int            lat_left = 0;

    logic [11:0]   eq [N];
    int            eq_head = 0;
    int            eq_cnt = 0;

    function automatic logic [11:0] res_of(input int k);
        return 12'((k * 977 + 313) & 12'hFFF);
    endfunction

    function automatic int exp_len();
        for (int i = 0; i < N; i++) if (cc[i][1]) return i + 1;
        return N;
    endfunction

    function automatic int exp_irqs();
        int c = 0;
        for (int i = 0; i < exp_len(); i++) if (cc[i][2]) c++;
        return c;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic apply_cfg();
        for (int i = 0; i < N; i++) begin
            cfg_sel[i*SW +: SW] = cs[i];
            cfg_ctl[i*4 +: 4]   = cc[i];
        end
    endtask

    // converter model and expected-FIFO bookkeeping
    always @(negedge clk) begin
        if (rst) begin
            conv_done = 1'b0;
            pending   = 0;
        end else begin
            conv_done = 1'b0;
            if (pending) begin
                if (lat_left == 0) begin
                    conv_result = res_of(conv_total);
                    conv_done   = 1'b1;
                    pending     = 0;
                    if (busy) begin
                        if (eq_cnt < N) begin
                            eq[(eq_head + eq_cnt) % N] = conv_result;
                            eq_cnt++;
                        end
                    end
                    conv_total++;
                end else begin
                    lat_left--;
                end
            end
            if (conv_start) begin
                if (log_n < 64) begin
                    log_sel[log_n]  = conv_sel;
                    log_diff[log_n] = conv_diff;
                end
                log_n++;
                pending  = 1;
                lat_left = $urandom_range(0, 3);
            end
        end
    end

    always @(negedge clk) if (!rst && irq) irq_cnt++;

    task automatic run_seq(input bit extra_init);
        int guard = 0;
        log_n   = 0;
        irq_cnt = 0;
        initiate = 1'b1;
        step(1);
        initiate = 1'b0;
        if (extra_init) begin
            step(2);
            initiate = 1'b1;
            step(1);
            initiate = 1'b0;
            step(3);
            initiate = 1'b1;
            step(1);
            initiate = 1'b0;
        end
        while (busy && guard < 400) begin
            step(1);
            guard++;
        end
        step(1);
    endtask

    task automatic verify_seq(input string tag);
        int len = exp_len();
        chk({tag, " R4 slot count"}, log_n, len);
        for (int i = 0; i < len && i < log_n; i++) begin
            chk({tag, " R2/R6 conv_sel"}, log_sel[i], cc[i][3] ? {SW{1'b1}} : cs[i]);
            chk({tag, " R3 conv_diff"}, log_diff[i], cc[i][0]);
        end
        chk({tag, " R5 irq pulses"}, irq_cnt, exp_irqs());
    endtask

    task automatic drain(input string tag);
        while (eq_cnt > 0) begin
            chk({tag, " R7 rd_data"}, rd_data, {20'b0, eq[eq_head]});
            chk({tag, " R12 not empty"}, fifo_empty, 0);
            rd_en = 1'b1;
            step(1);
            rd_en = 1'b0;
            eq_head = (eq_head + 1) % N;
            eq_cnt--;
        end
        chk({tag, " R12 empty after drain"}, fifo_empty, 1);
        chk({tag, " R12 head==tail"}, fifo_head, fifo_tail);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        step(3);
        rst = 1'b0;
        step(1);

        // R12 reset state
        chk("R12 reset busy", busy, 0);
        chk("R12 reset empty", fifo_empty, 1);
        chk("R12 reset full", fifo_full, 0);
        chk("R12 reset head", fifo_head, 0);
        chk("R12 reset tail", fifo_tail, 0);
        chk("R12 reset ovf", fifo_ovf, 0);
        chk("R12 reset unf", fifo_unf, 0);
        chk("R12 reset irq", irq, 0);

        // R1 initiate while disabled
        for (int i = 0; i < N; i++) begin cs[i] = SW'(i); cc[i] = 4'h0; end
        apply_cfg();
        log_n = 0;
        initiate = 1'b1; step(1); initiate = 1'b0; step(3);
        chk("R1 disabled busy", busy, 0);
        chk("R1 disabled no start", log_n, 0);

        // R2 repeated select, all irq, no end bit: runs all slots
        enable = 1'b1;
        for (int i = 0; i < N; i++) begin cs[i] = 4'd3; cc[i] = 4'b0100; end
        apply_cfg();
        run_seq(0);
        verify_seq("dir-repeat");
        chk("R12 tail after 8", fifo_tail, 0);
        chk("R12 full after 8", fifo_full, 1);
        drain("dir-repeat");

        // R4/R6 end at slot 4, sensor on slot 2, diff on slot 1
        for (int i = 0; i < N; i++) begin cs[i] = SW'(i + 5); cc[i] = 4'h0; end
        cc[1] = 4'b0001; cc[2] = 4'b1100; cc[4] = 4'b0110;
        apply_cfg();
        run_seq(0);
        verify_seq("dir-end5");
        chk("R12 tail after 5", fifo_tail, 5);

        // R8 second run without reading overflows (5 + 5 > 8)
        run_seq(0);
        verify_seq("dir-ovf");
        chk("R8 ovf set", fifo_ovf, 1);
        chk("R8 full", fifo_full, 1);
        chk("R8 tail==head", fifo_tail, fifo_head);
        clr_ovf = 1'b1; step(1); clr_ovf = 1'b0;
        chk("R10 ovf cleared", fifo_ovf, 0);
        drain("dir-ovf");

        // R9 read on empty
        begin
            logic [PW-1:0] h0;
            h0 = fifo_head;
            chk("R7 empty rd_data zero", rd_data, 0);
            rd_en = 1'b1; step(1); rd_en = 1'b0;
            chk("R9 unf set", fifo_unf, 1);
            chk("R9 head unchanged", fifo_head, h0);
            chk("R9 still empty", fifo_empty, 1);
            rd_en = 1'b1; clr_unf = 1'b1; step(1); rd_en = 1'b0; clr_unf = 1'b0;
            chk("R10 set wins over clear", fifo_unf, 1);
            clr_unf = 1'b1; step(1); clr_unf = 1'b0;
            chk("R10 unf cleared", fifo_unf, 0);
        end

        // R11 initiate while busy ignored
        for (int i = 0; i < N; i++) begin cs[i] = SW'(i); cc[i] = 4'b0000; end
        cc[7] = 4'b0100;
        apply_cfg();
        run_seq(1);
        verify_seq("R11 busy-init");
        drain("R11 busy-init");

        // R1 abort by dropping enable
        initiate = 1'b1; step(1); initiate = 1'b0;
        step(4);
        enable = 1'b0;
        step(1);
        chk("R1 abort busy", busy, 0);
        step(8);
        chk("R1 abort busy stays low", busy, 0);
        enable = 1'b1;
        drain("R1 abort");

        // random sequences
        for (int t = 0; t < 30; t++) begin
            for (int i = 0; i < N; i++) begin
                cs[i] = SW'($urandom_range(0, 15));
                cc[i] = 4'($urandom_range(0, 15));
                if ($urandom_range(0, 2) != 0) cc[i][1] = 1'b0;
            end
            apply_cfg();
            run_seq(0);
            verify_seq("rand");
            chk("rand R8 no ovf", fifo_ovf, 0);
            drain("rand");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule